// File: doc/BRIEF.md
# Interrupt source state controller

This block keeps the state of a parameterised group of interrupt sources and decides when each one must be offered to the presentation side. Each source is strapped as either a level source or a message (edge) source. Every source holds a target server number, a priority, a saved priority and a small set of status flags. A priority of all ones (0xFF) masks the source.

Sources are stimulated by their interrupt lines. Configuration writes address a local source index and load its server, priority and saved priority. The presentation side returns reject, end-of-interrupt (EOI) and resend messages, where reject and EOI name a global source number.

Whenever a source must be presented, it raises a pending-request bit. A fixed-order picker drains these bits one per cycle, lowest index first. Each grant produces a single-cycle present request that carries the server, the global number (base offset plus local index), the priority and the saved priority.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset every source is masked (priority 0xFF, saved priority 0xFF) with all status flags clear, and pres_valid is low. A source that was unmasked before reset presents nothing on a line event afterwards.
- R2: A present request is one cycle with pres_valid high. It carries the source's server, global number BASE + index, priority and saved priority, and appears two clock edges after the input that caused it.
- R3: A rising edge on a masked message source sets its masked-pending flag and presents nothing. A later configuration write with priority 0xFF leaves the flag set. A later write with any other priority clears the flag and presents the source once.
- R4: A level source with a priority other than 0xFF is presented once when its line rises. While it stays sent, holding the line high presents nothing more.
- R5: A reject naming a message source sets its rejected flag. A resend then clears the flag and presents the source again if it is unmasked. A resend with the flag clear presents nothing.
- R6: A reject or an EOI naming a level source clears its sent flag without presenting it. A following resend presents it again only while its line is high.
- R7: An EOI naming a message source changes nothing, so a following resend presents nothing.
- R8: Sources that need presentation in the same cycle are issued one per cycle in ascending index order, and none is lost.
- R9: A reject or EOI whose number lies outside BASE to BASE+NUM_SRC-1 is ignored.
- R10: A level source whose line is high while masked presents nothing. It is presented once when a configuration write gives it a priority other than 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_is_level | input | NUM_SRC | Per-source type strap: 1 level, 0 message |
| irq_line | input | NUM_SRC | Per-source interrupt lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index being configured |
| cfg_server | input | SRV_W | Target server to store |
| cfg_prio | input | 8 | Priority to store (0xFF masks) |
| cfg_saved_prio | input | 8 | Saved priority to store |
| rej_valid | input | 1 | Reject message strobe |
| rej_num | input | GNUM_W | Global number of the rejected source |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | GNUM_W | Global number being completed |
| resend_valid | input | 1 | Resend request to all sources |
| pres_valid | output | 1 | Present request valid (one cycle) |
| pres_server | output | SRV_W | Target server of the request |
| pres_num | output | GNUM_W | Global source number |
| pres_prio | output | 8 | Priority of the request |
| pres_saved_prio | output | 8 | Saved priority of the source |

## Verification
Message sources are driven with single rising edges, both masked and unmasked, and then with reject-and-resend or EOI-and-resend pairs. This separates a replayed event from a lost one and from a false replay. Level sources are held high across several cycles, through EOI, reject and resend, and with the line dropped before a resend. This shows whether the sent flag allows exactly one presentation per assertion. Three sources rising together show the issue order and that no request is dropped. Reject and EOI numbers just beyond the window would wrap onto real entries under a truncating decode, so they expose a missing range check.

// File: rtl/irq_src_pkg.sv
`timescale 1ns/1ps
package irq_src_pkg;

  localparam logic [7:0] PRIO_OFF = 8'hFF;

  typedef struct packed {
    logic asserted;   // registered line value
    logic sent;       // level: presented and not yet acknowledged
    logic rejected;   // message: bounced by presentation side
    logic mpend;      // message: event arrived while masked
  } src_stat_t;

  function automatic int unsigned glob_of(int unsigned idx, int unsigned base);
    return base + idx;
  endfunction

  function automatic logic in_window(int unsigned num, int unsigned base,
                                     int unsigned cnt);
    return (num >= base) && (num < base + cnt);
  endfunction

  function automatic int unsigned local_of(int unsigned num, int unsigned base);
    return num - base;
  endfunction

endpackage

// File: rtl/irq_src_slot.sv
`timescale 1ns/1ps
module irq_src_slot
  import irq_src_pkg::*;
#(
  parameter int unsigned SRV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_level,
  input  logic             line,
  input  logic             cfg_hit,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic [7:0]       cfg_saved,
  input  logic             rej_hit,
  input  logic             eoi_hit,
  input  logic             resend,
  input  logic             grant,
  output logic             req,
  output logic [SRV_W-1:0] server,
  output logic [7:0]       prio,
  output logic [7:0]       saved_prio
);

  src_stat_t        stat_q, stat_n;
  logic [7:0]       prio_q, saved_q, prio_n;
  logic [SRV_W-1:0] srv_q;
  logic             req_q;

  // Named internal events
  logic rise;      // line went from low to high
  logic fire;      // source needs presentation this cycle
  logic masked_now;

  assign rise       = line & ~stat_q.asserted;
  assign masked_now = (prio_q == PRIO_OFF);
  assign prio_n     = cfg_hit ? cfg_prio : prio_q;

  always_comb begin
    stat_n          = stat_q;
    stat_n.asserted = line;
    fire            = 1'b0;
    if (is_level) begin
      if (rej_hit || eoi_hit) stat_n.sent = 1'b0;
      if ((rise || resend || cfg_hit) && (prio_n != PRIO_OFF) && line &&
          !stat_n.sent) begin
        stat_n.sent = 1'b1;
        fire        = 1'b1;
      end
    end else begin
      if (rise) begin
        if (masked_now) stat_n.mpend = 1'b1;
        else            fire = 1'b1;
      end
      if (rej_hit) stat_n.rejected = 1'b1;
      if (resend && stat_n.rejected) begin
        stat_n.rejected = 1'b0;
        if (prio_n != PRIO_OFF) fire = 1'b1;
      end
      if (cfg_hit && stat_n.mpend && (prio_n != PRIO_OFF)) begin
        stat_n.mpend = 1'b0;
        fire         = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      prio_q  <= PRIO_OFF;
      saved_q <= PRIO_OFF;
      srv_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      stat_q <= stat_n;
      prio_q <= prio_n;
      if (cfg_hit) begin
        saved_q <= cfg_saved;
        srv_q   <= cfg_server;
      end
      req_q <= (req_q & ~grant) | fire;
    end
  end

  assign req        = req_q;
  assign server     = srv_q;
  assign prio       = prio_q;
  assign saved_prio = saved_q;

  // R3
  mpend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && rise && masked_now && !cfg_hit) |=> stat_q.mpend);

  // R4
  sent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_level && stat_q.sent && !rej_hit && !eoi_hit) |=> stat_q.sent);

  // R5
  rej_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_level && rej_hit && !resend) |=> stat_q.rejected);

  // R7
  msg_never_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_level |-> !stat_q.sent);

  // R8
  req_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !grant) |=> req_q);

endmodule

// File: rtl/irq_src_pick.sv
`timescale 1ns/1ps
module irq_src_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  assign any   = |req;
  assign grant = req & (~req + N'(1));

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  // R8
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((req & ((N'(1) << idx) - N'(1))) == '0));

  // R8
  grant_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (grant == (N'(1) << idx)));

endmodule

// File: rtl/irq_src_ctrl.sv
`timescale 1ns/1ps
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned SRV_W   = 4,
  parameter int unsigned GNUM_W  = 16,
  parameter int unsigned BASE    = 64,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_is_level,
  input  logic [NUM_SRC-1:0] irq_line,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [SRV_W-1:0]   cfg_server,
  input  logic [7:0]         cfg_prio,
  input  logic [7:0]         cfg_saved_prio,
  input  logic               rej_valid,
  input  logic [GNUM_W-1:0]  rej_num,
  input  logic               eoi_valid,
  input  logic [GNUM_W-1:0]  eoi_num,
  input  logic               resend_valid,
  output logic               pres_valid,
  output logic [SRV_W-1:0]   pres_server,
  output logic [GNUM_W-1:0]  pres_num,
  output logic [7:0]         pres_prio,
  output logic [7:0]         pres_saved_prio
);

  logic [NUM_SRC-1:0] cfg_hit, rej_hit, eoi_hit, req, grant;
  logic [SRV_W-1:0]   slot_srv   [NUM_SRC];
  logic [7:0]         slot_prio  [NUM_SRC];
  logic [7:0]         slot_saved [NUM_SRC];
  logic [IDX_W-1:0]   arb_idx;
  logic               arb_any;
  logic               rej_in, eoi_in;

  assign rej_in = in_window(32'(rej_num), BASE, NUM_SRC);
  assign eoi_in = in_window(32'(eoi_num), BASE, NUM_SRC);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    assign cfg_hit[i] = cfg_we && (cfg_idx == IDX_W'(i));
    assign rej_hit[i] = rej_valid && rej_in &&
                        (local_of(32'(rej_num), BASE) == i);
    assign eoi_hit[i] = eoi_valid && eoi_in &&
                        (local_of(32'(eoi_num), BASE) == i);

    irq_src_slot #(.SRV_W(SRV_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .is_level   (src_is_level[i]),
      .line       (irq_line[i]),
      .cfg_hit    (cfg_hit[i]),
      .cfg_server (cfg_server),
      .cfg_prio   (cfg_prio),
      .cfg_saved  (cfg_saved_prio),
      .rej_hit    (rej_hit[i]),
      .eoi_hit    (eoi_hit[i]),
      .resend     (resend_valid),
      .grant      (grant[i]),
      .req        (req[i]),
      .server     (slot_srv[i]),
      .prio       (slot_prio[i]),
      .saved_prio (slot_saved[i])
    );
  end

  irq_src_pick #(.N(NUM_SRC), .IW(IDX_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant),
    .idx   (arb_idx),
    .any   (arb_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_valid      <= 1'b0;
      pres_server     <= '0;
      pres_num        <= '0;
      pres_prio       <= PRIO_OFF;
      pres_saved_prio <= PRIO_OFF;
    end else begin
      pres_valid <= arb_any;
      if (arb_any) begin
        pres_server     <= slot_srv[arb_idx];
        pres_num        <= GNUM_W'(glob_of(32'(arb_idx), BASE));
        pres_prio       <= slot_prio[arb_idx];
        pres_saved_prio <= slot_saved[arb_idx];
      end
    end
  end

  // R2
  pres_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> in_window(32'(pres_num), BASE, NUM_SRC));

  // R9
  stray_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rej_valid && !rej_in) || (eoi_valid && !eoi_in)) |->
      ((rej_hit | eoi_hit) == '0));

endmodule

// File: tb/irq_src_ctrl_test.sv
`timescale 1ns/1ps
module irq_src_ctrl_test;

  localparam int NS   = 16;
  localparam int SW   = 4;
  localparam int GW   = 16;
  localparam int BASE = 64;
  localparam int IW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_is_level = 16'hFF00;  // 8..15 level, 0..7 message
  logic [NS-1:0] irq_line = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [SW-1:0] cfg_server = '0;
  logic [7:0]    cfg_prio = 8'hFF;
  logic [7:0]    cfg_saved_prio = 8'hFF;
  logic          rej_valid = 1'b0;
  logic [GW-1:0] rej_num = '0;
  logic          eoi_valid = 1'b0;
  logic [GW-1:0] eoi_num = '0;
  logic          resend_valid = 1'b0;
  logic          pres_valid;
  logic [SW-1:0] pres_server;
  logic [GW-1:0] pres_num;
  logic [7:0]    pres_prio;
  logic [7:0]    pres_saved_prio;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_src_ctrl #(.NUM_SRC(NS), .SRV_W(SW), .GNUM_W(GW), .BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .src_is_level(src_is_level), .irq_line(irq_line),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
    .cfg_prio(cfg_prio), .cfg_saved_prio(cfg_saved_prio),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid),
    .eoi_num(eoi_num), .resend_valid(resend_valid), .pres_valid(pres_valid),
    .pres_server(pres_server), .pres_num(pres_num), .pres_prio(pres_prio),
    .pres_saved_prio(pres_saved_prio)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic int gnum(int idx);
    return BASE + idx;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  // Sample at the current negedge.
  task automatic expect_idle(string tag);
    checks++;
    if (pres_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: pres_valid=%0b num=%0d expected idle", tag, pres_valid,
               pres_num);
    end
  endtask

  task automatic expect_pres(string tag, int srv, int num, int pr, int sv);
    checks++;
    if (pres_valid !== 1'b1 || pres_server !== SW'(srv) ||
        pres_num !== GW'(num) || pres_prio !== 8'(pr) ||
        pres_saved_prio !== 8'(sv)) begin
      errors++;
      $display("FAIL %s: got v=%0b srv=%0d num=%0d prio=%0h saved=%0h, expected v=1 srv=%0d num=%0d prio=%0h saved=%0h",
               tag, pres_valid, pres_server, pres_num, pres_prio,
               pres_saved_prio, srv, num, pr, sv);
    end
  endtask

  // Each operation drives for one cycle and returns at the negedge where its
  // effect is visible on the present port (two clock edges later).
  task automatic do_cfg(int idx, int srv, int pr, int sv);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_server = SW'(srv);
    cfg_prio = 8'(pr); cfg_saved_prio = 8'(sv);
    step();
    cfg_we = 1'b0;
    step();
  endtask

  task automatic pulse_line(int idx);
    irq_line[idx] = 1'b1;
    step();
    irq_line[idx] = 1'b0;
    step();
  endtask

  task automatic raise_line(int idx);
    irq_line[idx] = 1'b1;
    step();
    step();
  endtask

  task automatic do_reject(int num);
    rej_valid = 1'b1; rej_num = GW'(num);
    step();
    rej_valid = 1'b0;
    step();
  endtask

  task automatic do_eoi(int num);
    eoi_valid = 1'b1; eoi_num = GW'(num);
    step();
    eoi_valid = 1'b0;
    step();
  endtask

  task automatic do_resend();
    resend_valid = 1'b1;
    step();
    resend_valid = 1'b0;
    step();
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    step();
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    apply_reset();
    expect_idle("R1 reset idle");
    pulse_line(0);
    expect_idle("R1 masked after reset");
    step();
    expect_idle("R3 masked event not presented");
  endtask

  task automatic t_msg_unmask();
    do_cfg(0, 5, 8'hFF, 8'h11);
    expect_idle("R3 cfg with 0xFF keeps pending");
    do_cfg(0, 3, 5, 8'h22);
    expect_pres("R3 unmask presents pending", 3, gnum(0), 5, 8'h22);
    step();
    expect_idle("R3 pending presented once");
  endtask

  task automatic t_msg_direct();
    do_cfg(1, 2, 4, 8'h33);
    expect_idle("R2 cfg without pending is silent");
    pulse_line(1);
    expect_pres("R2 message edge presented", 2, gnum(1), 4, 8'h33);
    step();
    expect_idle("R2 single-cycle request");
  endtask

  task automatic t_msg_reject();
    do_resend();
    expect_idle("R5 resend without reject");
    do_reject(gnum(1));
    expect_idle("R5 reject alone silent");
    do_resend();
    expect_pres("R5 resend replays rejected", 2, gnum(1), 4, 8'h33);
    do_resend();
    expect_idle("R5 second resend silent");
  endtask

  task automatic t_msg_eoi();
    do_eoi(gnum(1));
    do_resend();
    expect_idle("R7 EOI on message has no effect");
  endtask

  task automatic t_level();
    do_cfg(8, 1, 2, 8'h44);
    expect_idle("R4 cfg with line low silent");
    raise_line(8);
    expect_pres("R4 level rise presented", 1, gnum(8), 2, 8'h44);
    repeat (4) step();
    expect_idle("R4 held line not re-presented");
    do_eoi(gnum(8));
    expect_idle("R6 EOI alone silent");
    do_resend();
    expect_pres("R6 resend after EOI re-presents", 1, gnum(8), 2, 8'h44);
  endtask

  task automatic t_range();
    do_eoi(gnum(NS) + 8);
    do_resend();
    expect_idle("R9 EOI outside window ignored");
    do_reject(gnum(NS));
    do_resend();
    expect_idle("R9 reject outside window ignored");
    do_reject(BASE - 1);
    do_resend();
    expect_idle("R9 reject below window ignored");
  endtask

  task automatic t_level_reject();
    do_reject(gnum(8));
    expect_idle("R6 reject alone silent");
    do_resend();
    expect_pres("R6 resend after reject", 1, gnum(8), 2, 8'h44);
    do_eoi(gnum(8));
    irq_line[8] = 1'b0;
    step();
    step();
    do_resend();
    expect_idle("R6 resend with line low silent");
  endtask

  task automatic t_level_masked();
    raise_line(9);
    expect_idle("R10 masked level silent");
    do_cfg(9, 5, 7, 8'h55);
    expect_pres("R10 unmask presents level", 5, gnum(9), 7, 8'h55);
    step();
    expect_idle("R10 presented once");
    irq_line[9] = 1'b0;
    step();
  endtask

  task automatic t_order();
    do_cfg(2, 6, 9, 8'h01);
    do_cfg(3, 7, 3, 8'h02);
    do_cfg(4, 8, 0, 8'h03);
    irq_line[4] = 1'b1; irq_line[2] = 1'b1; irq_line[3] = 1'b1;
    step();
    irq_line[4:2] = 3'b000;
    step();
    expect_pres("R8 first lowest index", 6, gnum(2), 9, 8'h01);
    step();
    expect_pres("R8 second index", 7, gnum(3), 3, 8'h02);
    step();
    expect_pres("R8 third index", 8, gnum(4), 0, 8'h03);
    step();
    expect_idle("R8 queue drained");
  endtask

  task automatic t_reset_again();
    apply_reset();
    expect_idle("R1 second reset idle");
    pulse_line(1);
    expect_idle("R1 unmasked source masked by reset");
    do_cfg(1, 9, 6, 8'h66);
    expect_pres("R3 pending after reset replayed", 9, gnum(1), 6, 8'h66);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step();
    t_reset();
    t_msg_unmask();
    t_msg_direct();
    t_msg_reject();
    t_msg_eoi();
    t_level();
    t_range();
    t_level_reject();
    t_level_masked();
    t_order();
    t_reset_again();
    repeat (3) step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule